// File: doc/BRIEF.md
# General-Purpose I/O Port with Hardware Blink

This block is a bank of general-purpose I/O lines behind a plain register port: one write strobe, an address, write data and a combinational read-data bus. Software picks the direction of each line, sets the static level of each output, inverts the sense of each input, and lets any output line flash under hardware control.

Each line has a blink enable. When it is set, the line drives a square wave instead of its static output bit. A single free-running timer sets the half-period of that wave in clock cycles. Every blinking line shares that timer, so all of them change level on the same clock edge. The input pins are synchronized with two flops. Each synchronized bit is then XORed with its polarity bit and can be read at a dedicated read-only offset. The pad enables come straight from the direction register. Every line resets to an input, so no pad is driven until software configures it.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output, blink and polarity registers read 0. The direction register reads all ones. `pad_oe` is 0 for every line.
- R2: Byte offsets 0x00 (output level), 0x04 (direction), 0x08 (blink enable) and 0x0C (input polarity) are written when `wr_en` is high at a rising clock edge. From the next cycle they read back the written value.
- R3: A direction bit of 1 makes its line an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1), from the cycle after the write.
- R4: An output line with blink disabled drives its output-register bit on `pad_out`. A line configured as input drives 0 on `pad_out`.
- R5: An output line with blink enabled drives the shared blink phase on `pad_out`. The phase toggles once every `BLINK_HALF` clock cycles, and all blinking output lines carry the same level at all times.
- R6: Offset 0x10 returns each synchronized pin value XORed with its input-polarity bit (a polarity bit of 1 inverts the line).
- R7: A change on `pad_in` appears at offset 0x10 after exactly two rising clock edges and not after one.
- R8: Offset 0x10 is read-only. A write to it leaves every register and the 0x10 readback unchanged.
- R9: A read of any offset other than the five above returns 0, and a write to such an offset changes no register.
- R10: Setting the blink enable of an input line neither enables its pad nor drives `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | NUM_LINES | Write data |
| rdata | output | NUM_LINES | Combinational read data for `addr` |
| pad_in | input | NUM_LINES | Pin levels from the pads (asynchronous) |
| pad_out | output | NUM_LINES | Levels driven to the pads |
| pad_oe | output | NUM_LINES | Pad driver enables, 1 = driving |

## Verification
The bench builds the port with all 32 lines and `BLINK_HALF` set to 6. With that setting, several full blink periods fit in a few dozen cycles, so the bench can measure the interval between toggles exactly and compare the flashing lines against one another. The full width lets the register vectors use patterns that differ in every byte. It also lets the two-edge synchronizer delay be probed one edge at a time through the read-only offset.

// File: rtl/gpio_port_pkg.sv
// Package: register offsets and decode select codes shared by the GPIO port.
// Assumes byte offsets fit in 8 bits; the port's ADDR_W truncates them.
package gpio_port_pkg;

    localparam logic [7:0] OFS_LEVEL = 8'h00;
    localparam logic [7:0] OFS_DIR   = 8'h04;
    localparam logic [7:0] OFS_FLASH = 8'h08;
    localparam logic [7:0] OFS_INV   = 8'h0C;
    localparam logic [7:0] OFS_SENSE = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_DIR,
        SEL_FLASH,
        SEL_INV,
        SEL_SENSE
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherence is promised across bits.
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Purpose: shift the raw pins through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;

endmodule

// File: rtl/gpio_blink_timer.sv
// Module: free-running half-period counter and shared blink phase.
// Assumes HALF_CYCLES >= 1; the phase toggles every HALF_CYCLES clocks.
module gpio_blink_timer #(
    parameter int HALF_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] count;
    logic          wrap;

    // Purpose: flag the last cycle of each half-period.
    always_comb begin
        wrap = (count == LAST);
    end

    // Purpose: advance the counter and flip the phase when it wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            count <= '0;
            phase <= ~phase;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/gpio_reg_bank.sv
// Module: address decode, the four writable registers and the read mux.
// Assumes a single-cycle write strobe; reads are combinational on addr.
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      sense_val,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      level_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      flash_q,
    output logic [N-1:0]      inv_q
);

    reg_sel_e sel;

    // Purpose: map the byte offset to a register select (full compare).
    always_comb begin
        if (addr == ADDR_W'(OFS_LEVEL))      sel = SEL_LEVEL;
        else if (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_FLASH)) sel = SEL_FLASH;
        else if (addr == ADDR_W'(OFS_INV))   sel = SEL_INV;
        else if (addr == ADDR_W'(OFS_SENSE)) sel = SEL_SENSE;
        else                                 sel = SEL_NONE;
    end

    // Purpose: update the selected writable register; the sense view has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '1;
            flash_q <= '0;
            inv_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_LEVEL: level_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_FLASH: flash_q <= wdata;
                SEL_INV:   inv_q   <= wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: return the selected register, zero for unmapped offsets.
    always_comb begin
        case (sel)
            SEL_LEVEL: rdata = level_q;
            SEL_DIR:   rdata = dir_q;
            SEL_FLASH: rdata = flash_q;
            SEL_INV:   rdata = inv_q;
            SEL_SENSE: rdata = sense_val;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_drive.sv
// Module: per-line pad enable and output selection between static level and blink.
// Assumes dir bit 1 = input; a line that is not driving shows 0 on pad_out.
module gpio_pad_drive #(
    parameter int N = 32
) (
    input  logic [N-1:0] level_q,
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] flash_q,
    input  logic         phase,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);

    for (genvar i = 0; i < N; i++) begin : g_line
        // Purpose: enable the driver for outputs and pick blink or static level.
        always_comb begin
            pad_oe[i]  = ~dir_q[i];
            pad_out[i] = pad_oe[i] & (flash_q[i] ? phase : level_q[i]);
        end
    end

endmodule

// File: rtl/gpio_port.sv
// Module: top of the GPIO port; ties together the synchronizer, register bank,
// blink timer and pad drive. Assumes a synchronous active-low reset.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int ADDR_W     = 5,
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe
);

    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] sense_val;
    logic [NUM_LINES-1:0] level_q;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] flash_q;
    logic [NUM_LINES-1:0] inv_q;
    logic                 phase;

    gpio_sync2 #(.WIDTH(NUM_LINES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // Purpose: apply the per-line input inversion to the synchronized pins.
    always_comb begin
        sense_val = pin_sync ^ inv_q;
    end

    gpio_reg_bank #(.N(NUM_LINES), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .sense_val (sense_val),
        .rdata     (rdata),
        .level_q   (level_q),
        .dir_q     (dir_q),
        .flash_q   (flash_q),
        .inv_q     (inv_q)
    );

    gpio_blink_timer #(.HALF_CYCLES(BLINK_HALF)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    gpio_pad_drive #(.N(NUM_LINES)) i_pads (
        .level_q (level_q),
        .dir_q   (dir_q),
        .flash_q (flash_q),
        .phase   (phase),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

endmodule

// File: rtl/gpio_port_chk.sv
// Module: property checker for gpio_port, attached by bind.
// Assumes it observes the top's ports and its register outputs.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      rdata,
    input logic [N-1:0]      pad_in,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      pad_oe,
    input logic [N-1:0]      level_q,
    input logic [N-1:0]      dir_q,
    input logic [N-1:0]      flash_q,
    input logic [N-1:0]      inv_q
);

    logic [1:0] since_rst;
    logic       mapped;
    logic [N-1:0] flashing;

    // Purpose: count cycles since reset (saturating) to bound $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Purpose: identify mapped offsets and lines that are blinking outputs.
    always_comb begin
        mapped = (addr == ADDR_W'(OFS_LEVEL)) || (addr == ADDR_W'(OFS_DIR)) ||
                 (addr == ADDR_W'(OFS_FLASH)) || (addr == ADDR_W'(OFS_INV)) ||
                 (addr == ADDR_W'(OFS_SENSE));
        flashing = pad_oe & flash_q;
    end

    a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == ~$past(wdata)));

    a_r4_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    a_r5_common_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out & flashing) == '0) || ((pad_out & flashing) == flashing)));

    a_r7_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_SENSE) && since_rst >= 2'd2) |->
            (rdata == ($past(pad_in, 2) ^ inv_q)));

    a_r8_sense_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_SENSE)) |=>
            ($stable(level_q) && $stable(dir_q) && $stable(flash_q) && $stable(inv_q)));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!mapped) |-> (rdata == '0));

endmodule

bind gpio_port gpio_port_chk #(.N(NUM_LINES), .ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .level_q (level_q),
    .dir_q   (dir_q),
    .flash_q (flash_q),
    .inv_q   (inv_q)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;

    localparam int N    = 32;
    localparam int AW   = 5;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gpio_port #(.NUM_LINES(N), .ADDR_W(AW), .BLINK_HALF(HALF)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [N-1:0]  wd;
        logic [N-1:0]  exp_rd;
        logic [N-1:0]  exp_oe;
    } vec_t;

    // R2/R3 vectors: write, read back, and the pad enables that follow.
    localparam vec_t VECS [8] = '{
        '{5'h00, 32'h12345678, 32'h12345678, 32'h00000000},
        '{5'h04, 32'hFFFF0000, 32'hFFFF0000, 32'h0000FFFF},
        '{5'h08, 32'h0000FF00, 32'h0000FF00, 32'h0000FFFF},
        '{5'h0C, 32'h5A5A5A5A, 32'h5A5A5A5A, 32'h0000FFFF},
        '{5'h00, 32'h00000000, 32'h00000000, 32'h0000FFFF},
        '{5'h04, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
        '{5'h08, 32'h00000000, 32'h00000000, 32'h00000000},
        '{5'h0C, 32'h00000000, 32'h00000000, 32'h00000000}
    };

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(5'h00, v); chk("R1 level", v, '0);
        rd(5'h04, v); chk("R1 dir", v, '1);
        rd(5'h08, v); chk("R1 blink", v, '0);
        rd(5'h0C, v); chk("R1 pol", v, '0);
        chk("R1 pad_oe", pad_oe, '0);

        // R2/R3: vector table
        foreach (VECS[k]) begin
            wr(VECS[k].a, VECS[k].wd);
            rd(VECS[k].a, v);
            chk("R2 readback", v, VECS[k].exp_rd);
            chk("R3 pad_oe", pad_oe, VECS[k].exp_oe);
        end

        // R4/R10: lines 0-7 outputs, static on 0-3, blink on 4-7 and input line 8
        wr(5'h00, 32'h8000000F);
        wr(5'h04, 32'hFFFFFF00);
        wr(5'h08, 32'h000001F0);
        @(negedge clk);
        chk("R3 pad_oe mix", pad_oe, 32'h000000FF);
        chk("R4 static lines", pad_out & 32'h0000000F, 32'h0000000F);
        chk("R4 input lines quiet", pad_out & 32'hFFFFFF00, 32'h0);
        chk("R10 blink input no oe", pad_oe & 32'h00000100, 32'h0);

        // R5: measure two half-periods and compare the blinking lines
        begin
            logic prev;
            int gap;
            prev = pad_out[4];
            for (int t = 0; t < 3 * HALF && pad_out[4] == prev; t++) @(negedge clk);
            for (int p = 0; p < 2; p++) begin
                prev = pad_out[4];
                gap = 0;
                while (pad_out[4] == prev && gap < 4 * HALF) begin
                    @(negedge clk);
                    gap++;
                end
                chk("R5 half period", N'(gap), N'(HALF));
                chk("R5 lines agree", pad_out & 32'hF0, {N{pad_out[4]}} & 32'hF0);
                chk("R10 blink input idle", pad_out & 32'h100, 32'h0);
            end
        end

        // R6: polarity inversion
        wr(5'h0C, 32'hA5A5A5A5);
        @(negedge clk); pad_in = 32'h0F0F0F0F;
        repeat (3) @(negedge clk);
        rd(5'h10, v); chk("R6 data-in xor", v, 32'h0F0F0F0F ^ 32'hA5A5A5A5);

        // R7: exactly two edges of latency (polarity now A5A5A5A5)
        @(negedge clk); addr = 5'h10; pad_in = 32'hFFFF0000;
        @(negedge clk); #1 chk("R7 not after one edge", rdata, 32'h0F0F0F0F ^ 32'hA5A5A5A5);
        @(negedge clk); #1 chk("R7 after two edges", rdata, 32'hFFFF0000 ^ 32'hA5A5A5A5);

        // R8: data-in is read-only
        wr(5'h10, 32'hDEADBEEF);
        rd(5'h00, v); chk("R8 level kept", v, 32'h8000000F);
        rd(5'h04, v); chk("R8 dir kept", v, 32'hFFFFFF00);
        rd(5'h08, v); chk("R8 blink kept", v, 32'h000001F0);
        rd(5'h0C, v); chk("R8 pol kept", v, 32'hA5A5A5A5);
        rd(5'h10, v); chk("R8 data-in kept", v, 32'hFFFF0000 ^ 32'hA5A5A5A5);

        // R9: unmapped offsets
        rd(5'h14, v); chk("R9 read 0x14", v, '0);
        rd(5'h02, v); chk("R9 read 0x02", v, '0);
        rd(5'h1C, v); chk("R9 read 0x1C", v, '0);
        wr(5'h14, 32'h00000000);
        wr(5'h05, 32'h00000000);
        rd(5'h04, v); chk("R9 dir untouched", v, 32'hFFFFFF00);
        rd(5'h00, v); chk("R9 level untouched", v, 32'h8000000F);
        chk("R9 pad_oe untouched", pad_oe, 32'h000000FF);

        // R4: returning a line to input stops driving it
        wr(5'h04, 32'hFFFFFFFE);
        @(negedge clk);
        chk("R4 pad_out after dir change", pad_out & 32'hFE, 32'h0);
        chk("R4 line0 static", pad_out & 32'h1, 32'h1);

        // R1: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 pad_oe after reset", pad_oe, '0);
        rd(5'h0C, v); chk("R1 pol after reset", v, '0);

        finish_run();
    end

endmodule